// File: doc/BRIEF.md
# Address-Sequence Command Detector

This block sits beside a byte-wide memory bus and watches for a hidden command: an ordered run of six read accesses to fixed addresses. Five fixed addresses open the command, and the address of the sixth read chooses whether the command asks for a nonvolatile STORE or a nonvolatile RECALL. The block sees the bus in a synchronous clock domain. Each chip-select falling edge reaches it as a one-cycle access strobe, together with that access's address and write-enable level.

A complete and valid run produces a single one-clock request pulse on `store_req` or on `recall_req`. Any write, and any read whose address breaks the order, throws the partial run away. While the nonvolatile engine reports busy, the detector ignores every strobe and holds its progress at zero. The memory array, power sensing and the timing of the STORE and RECALL cycles themselves belong to other blocks.

Top module: `seqcmd_detect`

## Requirements
- R1: The opening five reads must carry the 14-bit addresses 0x0E38, 0x31C7, 0x03E0, 0x3C1F, 0x303F, in that order, with no other strobe between them.
- R2: A sixth read at 0x0FC0 produces a `store_req` pulse. A sixth read at 0x0C63 produces a `recall_req` pulse. Any other sixth address produces no pulse.
- R3: Only address bits 13:0 are compared. Bit 14 may take either value at any step without effect.
- R4: A strobe with `acc_we_n` low (a write) at any step discards the run and produces no pulse, whatever its address.
- R5: A read whose address is not the one expected at the current step discards the run.
- R6: Only cycles with `acc_stb` high count. Cycles without a strobe neither advance nor discard a run.
- R7: Each request pulse lasts exactly one clock. `store_req` and `recall_req` are never high together. The pulse appears in the cycle after the strobe that completes the run, and the detector is back at its start in that same cycle.
- R8: When a read discards a run but carries the first address 0x0E38, it counts as the first step of a new run.
- R9: While `busy` is high, strobes are ignored, progress is cleared, and no pulse is produced.
- R10: Synchronous active-low reset clears progress and drives both pulses low.
- R11: A strobe in the cycle right after a completing strobe is evaluated from the start of a new run, so a repeated sixth address does not fire again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| acc_stb | input | 1 | One-cycle strobe per chip-select falling edge |
| acc_addr | input | ADDR_W (15) | Address of the strobed access |
| acc_we_n | input | 1 | Write-enable level of the access, high for a read |
| busy | input | 1 | Nonvolatile cycle in progress |
| store_req | output | 1 | One-clock STORE request |
| recall_req | output | 1 | One-clock RECALL request |

## Verification
On every cycle the assertions check the following. The two pulses never overlap, and neither lasts more than one clock. Each pulse follows a read strobe that carried its own selecting address while not busy. No pulse follows a write strobe, and none follows a busy cycle. Only the bench's scenarios can show that the five opening addresses are required in order, and that a mismatch or a write partway through really loses the run. They also show that a discarding read at the first address restarts the run, that idle gaps are harmless, and that reset or busy in the middle of a run clears it, since each of these depends on history longer than one cycle.

// File: rtl/seqcmd_pkg.sv
// Shared constants for the address-sequence command detector.
// Assumes the command keys are 14 bits wide and that the opening run has five steps.
package seqcmd_pkg;

    localparam int CMP_W    = 14;
    localparam int N_PREFIX = 5;
    localparam int STEP_W   = $clog2(N_PREFIX + 1);

    localparam logic [CMP_W-1:0] STORE_KEY  = 14'h0FC0;
    localparam logic [CMP_W-1:0] RECALL_KEY = 14'h0C63;

    // Address expected at opening step idx (0 = first read).
    function automatic logic [CMP_W-1:0] prefix_key(input int idx);
        case (idx)
            0:       prefix_key = 14'h0E38;
            1:       prefix_key = 14'h31C7;
            2:       prefix_key = 14'h03E0;
            3:       prefix_key = 14'h3C1F;
            default: prefix_key = 14'h303F;
        endcase
    endfunction

    // Outcome of a single strobe at the final step.
    typedef enum logic [1:0] {
        FIRE_NONE   = 2'b00,
        FIRE_STORE  = 2'b01,
        FIRE_RECALL = 2'b10
    } fire_t;

endpackage

// File: rtl/seqcmd_match.sv
// Address comparators for the command detector.
// Compares the 14 low address bits against every opening key and both final keys.
// Assumes step is the number of opening reads already matched.
module seqcmd_match
    import seqcmd_pkg::*;
(
    input  logic [CMP_W-1:0]  addr,
    input  logic [STEP_W-1:0] step,
    output logic              hit_step,
    output logic              hit_first,
    output logic              hit_store,
    output logic              hit_recall
);

    logic [N_PREFIX-1:0] hit_vec;

    // One equality comparator per opening key.
    generate
        for (genvar g = 0; g < N_PREFIX; g++) begin : g_cmp
            assign hit_vec[g] = (addr == prefix_key(g));
        end
    endgenerate

    // Selects the comparator for the current step. No hit past the last opening step.
    always_comb begin
        hit_step = 1'b0;
        for (int i = 0; i < N_PREFIX; i++) begin
            if (step == STEP_W'(i)) hit_step = hit_vec[i];
        end
    end

    assign hit_first  = hit_vec[0];
    assign hit_store  = (addr == STORE_KEY);
    assign hit_recall = (addr == RECALL_KEY);

endmodule

// File: rtl/seqcmd_track.sv
// Progress tracker: counts matched opening reads and decides the completion outcome.
// Assumes one strobe per cycle at most. busy overrides every strobe.
module seqcmd_track
    import seqcmd_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              stb,
    input  logic              is_read,
    input  logic              busy,
    input  logic              hit_step,
    input  logic              hit_first,
    input  logic              hit_store,
    input  logic              hit_recall,
    output logic [STEP_W-1:0] step,
    output fire_t             fire
);

    localparam logic [STEP_W-1:0] LAST = STEP_W'(N_PREFIX);

    logic [STEP_W-1:0] step_nxt;

    // Next progress value and completion outcome for this cycle.
    always_comb begin
        step_nxt = step;
        fire     = FIRE_NONE;
        if (busy) begin
            step_nxt = '0;
        end else if (stb) begin
            if (!is_read) begin
                step_nxt = '0;
            end else if (step == LAST) begin
                step_nxt = hit_first ? STEP_W'(1) : '0;
                if (hit_store) begin
                    fire     = FIRE_STORE;
                    step_nxt = '0;
                end else if (hit_recall) begin
                    fire     = FIRE_RECALL;
                    step_nxt = '0;
                end
            end else if (hit_step) begin
                step_nxt = step + STEP_W'(1);
            end else begin
                step_nxt = hit_first ? STEP_W'(1) : '0;
            end
        end
    end

    // Progress register.
    always_ff @(posedge clk) begin
        if (!rst_n) step <= '0;
        else        step <= step_nxt;
    end

endmodule

// File: rtl/seqcmd_pulse.sv
// Registers the completion outcome into two one-clock request pulses.
// Assumes fire is FIRE_NONE on every cycle that follows a completion.
module seqcmd_pulse
    import seqcmd_pkg::*;
(
    input  logic  clk,
    input  logic  rst_n,
    input  fire_t fire,
    output logic  store_req,
    output logic  recall_req
);

    // Output pulse registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            store_req  <= 1'b0;
            recall_req <= 1'b0;
        end else begin
            store_req  <= (fire == FIRE_STORE);
            recall_req <= (fire == FIRE_RECALL);
        end
    end

endmodule

// File: rtl/seqcmd_detect.sv
// Top of the address-sequence command detector.
// Recognises six ordered reads at fixed addresses and emits a STORE or RECALL request.
// Assumes acc_stb is one cycle per chip-select falling edge. Address bits above 13 are ignored.
module seqcmd_detect
    import seqcmd_pkg::*;
#(
    parameter int ADDR_W = 15
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              acc_stb,
    input  logic [ADDR_W-1:0] acc_addr,
    input  logic              acc_we_n,
    input  logic              busy,
    output logic              store_req,
    output logic              recall_req
);

    logic [CMP_W-1:0]  cmp_addr;
    logic [STEP_W-1:0] step;
    logic              hit_step, hit_first, hit_store, hit_recall;
    fire_t             fire;

    assign cmp_addr = acc_addr[CMP_W-1:0];

    // Upper address bits take no part in matching.
    generate
        if (ADDR_W > CMP_W) begin : g_hi
            logic unused_hi;
            assign unused_hi = ^acc_addr[ADDR_W-1:CMP_W];
        end
    endgenerate

    seqcmd_match u_match (
        .addr       (cmp_addr),
        .step       (step),
        .hit_step   (hit_step),
        .hit_first  (hit_first),
        .hit_store  (hit_store),
        .hit_recall (hit_recall)
    );

    seqcmd_track u_track (
        .clk        (clk),
        .rst_n      (rst_n),
        .stb        (acc_stb),
        .is_read    (acc_we_n),
        .busy       (busy),
        .hit_step   (hit_step),
        .hit_first  (hit_first),
        .hit_store  (hit_store),
        .hit_recall (hit_recall),
        .step       (step),
        .fire       (fire)
    );

    seqcmd_pulse u_pulse (
        .clk        (clk),
        .rst_n      (rst_n),
        .fire       (fire),
        .store_req  (store_req),
        .recall_req (recall_req)
    );

endmodule

// File: rtl/seqcmd_detect_chk.sv
// Property checker for seqcmd_detect, attached by bind. Observes ports only.
module seqcmd_detect_chk
    import seqcmd_pkg::*;
#(
    parameter int ADDR_W = 15
) (
    input logic              clk,
    input logic              rst_n,
    input logic              acc_stb,
    input logic [ADDR_W-1:0] acc_addr,
    input logic              acc_we_n,
    input logic              busy,
    input logic              store_req,
    input logic              recall_req
);

    AST_REQ_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rst_n)
        !(store_req && recall_req)); // R7

    AST_STORE_ONE_WIDE: assert property (@(posedge clk) disable iff (!rst_n)
        store_req |=> !store_req); // R7

    AST_RECALL_ONE_WIDE: assert property (@(posedge clk) disable iff (!rst_n)
        recall_req |=> !recall_req); // R7

    AST_STORE_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
        store_req |-> $past(acc_stb && acc_we_n && !busy && acc_addr[CMP_W-1:0] == STORE_KEY)); // R2

    AST_RECALL_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
        recall_req |-> $past(acc_stb && acc_we_n && !busy && acc_addr[CMP_W-1:0] == RECALL_KEY)); // R2

    AST_WRITE_NO_FIRE: assert property (@(posedge clk) disable iff (!rst_n)
        (acc_stb && !acc_we_n) |=> !(store_req || recall_req)); // R4

    AST_BUSY_NO_FIRE: assert property (@(posedge clk) disable iff (!rst_n)
        busy |=> !(store_req || recall_req)); // R9

    AST_IDLE_NO_FIRE: assert property (@(posedge clk) disable iff (!rst_n)
        !acc_stb |=> !(store_req || recall_req)); // R6

endmodule

bind seqcmd_detect seqcmd_detect_chk #(.ADDR_W(ADDR_W)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .acc_stb    (acc_stb),
    .acc_addr   (acc_addr),
    .acc_we_n   (acc_we_n),
    .busy       (busy),
    .store_req  (store_req),
    .recall_req (recall_req)
);

// File: tb/sim_seqcmd_detect.sv
// Bench for seqcmd_detect. Vector entry layout: [17] we_n, [16] expected store,
// [15] expected recall, [14:0] address. One strobe per entry, on consecutive cycles.
module sim_seqcmd_detect;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        acc_stb = 1'b0;
    logic [14:0] acc_addr = '0;
    logic        acc_we_n = 1'b1;
    logic        busy = 1'b0;
    logic        store_req, recall_req;

    int n_chk  = 0;
    int n_fail = 0;

    always #4 clk = ~clk;

    seqcmd_detect #(.ADDR_W(15)) u0 (
        .clk(clk), .rst_n(rst_n), .acc_stb(acc_stb), .acc_addr(acc_addr),
        .acc_we_n(acc_we_n), .busy(busy), .store_req(store_req), .recall_req(recall_req)
    );

    localparam int NV = 47;
    localparam logic [17:0] VEC [NV] = '{
        // R1 R2: store run
        18'h20E38, 18'h231C7, 18'h203E0, 18'h23C1F, 18'h2303F, 18'h30FC0,
        // R3: recall run with bit 14 set throughout
        18'h24E38, 18'h271C7, 18'h243E0, 18'h27C1F, 18'h2703F, 18'h2CC63,
        // R4: write at the third step
        18'h20E38, 18'h231C7, 18'h003E0, 18'h23C1F, 18'h2303F, 18'h20FC0,
        // R5: foreign read at the fourth step
        18'h20E38, 18'h231C7, 18'h203E0, 18'h21234, 18'h23C1F, 18'h2303F, 18'h20FC0,
        // R8: first key breaks the run and restarts it
        18'h20E38, 18'h231C7, 18'h20E38, 18'h231C7, 18'h203E0, 18'h23C1F, 18'h2303F, 18'h30FC0,
        // R2: wrong sixth address, then the store key from the start
        18'h20E38, 18'h231C7, 18'h203E0, 18'h23C1F, 18'h2303F, 18'h20FC1, 18'h20FC0,
        // R11: recall then an immediate repeat of the recall key
        18'h20E38, 18'h231C7, 18'h203E0, 18'h23C1F, 18'h2303F, 18'h28C63, 18'h20C63
    };

    function automatic string vec_req(input int i);
        if (i < 6)  return "R1";
        if (i < 12) return "R3";
        if (i < 18) return "R4";
        if (i < 25) return "R5";
        if (i < 33) return "R8";
        if (i < 40) return "R2";
        return "R11";
    endfunction

    task automatic check(input string req, input logic exp_s, input logic exp_r);
        n_chk++;
        if (store_req !== exp_s || recall_req !== exp_r) begin
            n_fail++;
            $display("FAIL %s: store/recall = %b%b, expected %b%b", req, store_req, recall_req, exp_s, exp_r);
        end
    endtask

    // Drive one strobe at the falling edge, check the pulses just after the next rising edge.
    task automatic access(input logic we_n, input logic [14:0] a,
                          input logic exp_s, input logic exp_r, input string req);
        @(negedge clk);
        acc_stb = 1'b1; acc_we_n = we_n; acc_addr = a;
        @(posedge clk); #1;
        check(req, exp_s, exp_r);
    endtask

    task automatic idle(input int n, input string req);
        for (int k = 0; k < n; k++) begin
            @(negedge clk);
            acc_stb = 1'b0;
            @(posedge clk); #1;
            check(req, 1'b0, 1'b0);
        end
    endtask

    task automatic prefix(input string req);
        access(1'b1, 15'h0E38, 1'b0, 1'b0, req);
        access(1'b1, 15'h31C7, 1'b0, 1'b0, req);
        access(1'b1, 15'h03E0, 1'b0, 1'b0, req);
        access(1'b1, 15'h3C1F, 1'b0, 1'b0, req);
        access(1'b1, 15'h303F, 1'b0, 1'b0, req);
    endtask

    initial begin
        #(200000 * 8);
        n_fail++;
        n_chk++;
        $display("FAIL watchdog: run did not finish, expected completion");
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        // R10: reset state
        repeat (3) @(posedge clk);
        #1;
        check("R10", 1'b0, 1'b0);
        @(negedge clk);
        rst_n = 1'b1;

        // Table walk, one strobe per cycle
        for (int i = 0; i < NV; i++) begin
            access(VEC[i][17], VEC[i][14:0], VEC[i][16], VEC[i][15], vec_req(i));
        end
        idle(1, "R7");

        // R6: idle gaps between every step do not break the run
        access(1'b1, 15'h0E38, 1'b0, 1'b0, "R6");
        idle(3, "R6");
        access(1'b1, 15'h31C7, 1'b0, 1'b0, "R6");
        idle(1, "R6");
        access(1'b1, 15'h03E0, 1'b0, 1'b0, "R6");
        access(1'b1, 15'h3C1F, 1'b0, 1'b0, "R6");
        idle(2, "R6");
        access(1'b1, 15'h303F, 1'b0, 1'b0, "R6");
        idle(4, "R6");
        access(1'b1, 15'h0C63, 1'b0, 1'b1, "R6");
        idle(1, "R7");

        // R4: a write carrying the final key produces nothing
        prefix("R4");
        access(1'b0, 15'h0FC0, 1'b0, 1'b0, "R4");
        idle(1, "R4");

        // R9: busy in the middle of a run clears its progress
        access(1'b1, 15'h0E38, 1'b0, 1'b0, "R9");
        access(1'b1, 15'h31C7, 1'b0, 1'b0, "R9");
        @(negedge clk); busy = 1'b1; acc_stb = 1'b0;
        @(posedge clk); #1; check("R9", 1'b0, 1'b0);
        @(negedge clk); busy = 1'b0;
        access(1'b1, 15'h03E0, 1'b0, 1'b0, "R9");
        access(1'b1, 15'h3C1F, 1'b0, 1'b0, "R9");
        access(1'b1, 15'h303F, 1'b0, 1'b0, "R9");
        access(1'b1, 15'h0FC0, 1'b0, 1'b0, "R9");
        idle(1, "R9");

        // R9: a full run while busy is ignored
        @(negedge clk); busy = 1'b1;
        prefix("R9");
        access(1'b1, 15'h0FC0, 1'b0, 1'b0, "R9");
        idle(1, "R9");
        @(negedge clk); busy = 1'b0;
        access(1'b1, 15'h0FC0, 1'b0, 1'b0, "R9");

        // R10: reset in the middle of a run clears its progress
        prefix("R10");
        @(negedge clk); acc_stb = 1'b0; rst_n = 1'b0;
        @(posedge clk); #1; check("R10", 1'b0, 1'b0);
        @(negedge clk); rst_n = 1'b1;
        access(1'b1, 15'h0FC0, 1'b0, 1'b0, "R10");
        idle(1, "R10");

        // R8 R7: the store completes with the state ready for a fresh run at once
        prefix("R8");
        access(1'b1, 15'h4FC0, 1'b1, 1'b0, "R3");
        prefix("R11");
        access(1'b1, 15'h0C63, 1'b0, 1'b1, "R11");
        idle(1, "R7");

        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

endmodule